// File: doc/BRIEF.md
# Minimum-Mode Bus Cycle Controller

This block runs the external bus cycles of a single-master system whose address and data share one set of lines. A client offers one transfer at a time on a request port. The request carries a 20-bit address, a direction bit, a memory-or-I/O select, 16 bits of write data and a small status word. The controller walks the transfer through four clock states. In the first state it puts the address on the shared lines and pulses the address-latch strobe. In the following states it drives the read or write strobe, the data-buffer enable and the direction signal. For a write it also drives the data. Wait states are added for as long as the addressed device holds READY low. A read returns the sampled data word with a one-clock valid pulse.

Between transfers, an external master can ask for the bus with a hold request. The controller finishes any transfer already under way. It then lets go of the address, data and control lines by dropping their output enables, and it raises a hold acknowledge. The lines are driven again once the request is withdrawn. All outputs come from registers, and a synchronous active-high reset abandons any transfer at once.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are idle: `rd_n`, `wr_n`, `den_n` and `ctl_oe` at 1; `ale`, `ad_oe`, `hi_oe`, `hlda` and `rd_valid` at 0; `req_accept` at 0. A transfer in progress is abandoned.
- R2: In the idle state, with `hold` low and `req_valid` high, `req_accept` is high in the same cycle. After the next edge (T1), `ale` is 1 for exactly one clock, `{hi_out, ad_out}` equals `req_addr`, and `ad_oe` and `hi_oe` are 1. Every accepted request yields exactly one such cycle.
- R3: From T2 through T4, `hi_out` carries `req_stat` and `hi_oe` stays 1.
- R4: A read (`req_write`=0) holds `rd_n` low and `wr_n` high from T2 through the last T3/TW. `dtr_n` is 0 for the whole transfer, and `ad_oe` is 0 after T1. `rd_n` and `wr_n` are never both low.
- R5: A write (`req_write`=1) holds `wr_n` low from T2 through the last T3/TW. `dtr_n` is 1, and `ad_out` equals `req_wdata` with `ad_oe` at 1 from T2 through T4.
- R6: `den_n` is low in exactly the clocks where a strobe is low. `ready` is sampled only at the end of T3 and of each TW: each low sample adds one TW clock, so a strobe lasts 2 + (number of low samples) clocks. `ready` in T1 or T2 has no effect.
- R7: `m_io` is 1 for a memory transfer (`req_mem`=1) and 0 for I/O, and it does not change from T1 to T4.
- R8: For a read, `ad_in` is captured at the edge that ends the last T3/TW. It appears on `rd_data` with `rd_valid` high for the single T4 clock. A write never raises `rd_valid`.
- R9: `hold` is acted on only in the idle state, where it wins over a pending request (`req_accept` stays 0). One edge later, `hlda` is 1 and `ctl_oe`, `ad_oe` and `hi_oe` are 0. A `hold` raised during a transfer is granted only after its T4 and one idle clock.
- R10: At the first edge that samples `hold` low in the hold state, `hlda` returns to 0 and `ctl_oe` to 1. A pending request is accepted in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A transfer request is offered |
| req_accept | output | 1 | Request taken this cycle |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_wdata | input | DATA_W | Write data |
| req_stat | input | ADDR_W-DATA_W | Status driven on upper lines after T1 |
| ready | input | 1 | Device ready; low inserts wait states |
| hold | input | 1 | External master requests the bus |
| hlda | output | 1 | Bus released to external master |
| ad_in | input | DATA_W | Shared lines as seen from outside (read data) |
| ad_out | output | DATA_W | Shared lines driven value |
| ad_oe | output | 1 | Output enable of shared lines |
| hi_out | output | ADDR_W-DATA_W | Upper address/status lines |
| hi_oe | output | 1 | Output enable of upper lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dtr_n | output | 1 | 1 = data outbound, 0 = data inbound |
| m_io | output | 1 | 1 = memory, 0 = I/O |
| ctl_oe | output | 1 | Output enable of control strobes |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | rd_data valid (one clock in T4) |

## Verification
The assertions check several things on every cycle. The two strobes are never low together, and the direction and data-enable agree with whichever strobe is active. The address strobe lasts one clock, and a strobe stays low while READY is low. The memory/I/O select stays stable through a transfer. Hold acknowledge only appears after an idle cycle and always comes with all enables off. The bench scenarios show the properties that need a whole transfer to be seen: the address, status and data values, the exact strobe length for a given count of wait samples, that READY is ignored in T2, which edge captures the read word, hold deferred past a transfer, priority of hold over a pending request, and abort by reset.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5,
    S_HOLD = 3'd6
  } bus_state_e;
endpackage

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic       ready,
  input  logic       hold,
  output bus_state_e state_d,
  output logic       take,
  output logic       capture
);
  bus_state_e state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (hold)           state_d = S_HOLD;
        else if (req_valid) state_d = S_T1;
      end
      S_T1:       state_d = S_T2;
      S_T2:       state_d = S_T3;
      S_T3, S_TW: state_d = ready ? S_T4 : S_TW;
      S_T4:       state_d = S_IDLE;
      S_HOLD:     if (!hold) state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  // a request is taken only between transfers and only if no master wants the bus
  assign take    = !rst && (state_q == S_IDLE) && !hold && req_valid;
  // last data-phase clock: device is ready at the end of T3 or a wait state
  assign capture = ((state_q == S_T3) || (state_q == S_TW)) && ready;

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/mbus_drive.sv
module mbus_drive
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_state_e        state_d,
  input  logic              take,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [HI_W-1:0]   req_stat,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dtr_n,
  output logic              m_io,
  output logic              ctl_oe,
  output logic              hlda,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_wr;
  logic              lat_mem;
  logic [DATA_W-1:0] lat_wdata;
  logic [HI_W-1:0]   lat_stat;

  // fields seen by the output registers: fresh request on the accept edge, else latched copy
  logic [ADDR_W-1:0] f_addr;
  logic              f_wr;
  logic              f_mem;
  logic [DATA_W-1:0] f_wdata;
  logic [HI_W-1:0]   f_stat;
  logic              nx_addr, nx_strobe, nx_cyc;

  always_comb begin
    f_addr    = take ? req_addr  : lat_addr;
    f_wr      = take ? req_write : lat_wr;
    f_mem     = take ? req_mem   : lat_mem;
    f_wdata   = take ? req_wdata : lat_wdata;
    f_stat    = take ? req_stat  : lat_stat;
    nx_addr   = (state_d == S_T1);
    nx_strobe = (state_d == S_T2) || (state_d == S_T3) || (state_d == S_TW);
    nx_cyc    = nx_addr || nx_strobe || (state_d == S_T4);
  end

  always_ff @(posedge clk) begin
    if (take) begin
      lat_addr  <= req_addr;
      lat_wr    <= req_write;
      lat_mem   <= req_mem;
      lat_wdata <= req_wdata;
      lat_stat  <= req_stat;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ale      <= 1'b0;
      rd_n     <= 1'b1;
      wr_n     <= 1'b1;
      den_n    <= 1'b1;
      dtr_n    <= 1'b1;
      m_io     <= 1'b0;
      ad_oe    <= 1'b0;
      hi_oe    <= 1'b0;
      ctl_oe   <= 1'b1;
      hlda     <= 1'b0;
      ad_out   <= '0;
      hi_out   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      ale      <= nx_addr;
      rd_n     <= !(nx_strobe && !f_wr);
      wr_n     <= !(nx_strobe && f_wr);
      den_n    <= !nx_strobe;
      dtr_n    <= nx_cyc ? f_wr  : 1'b1;
      m_io     <= nx_cyc ? f_mem : 1'b0;
      ad_oe    <= nx_addr || (nx_cyc && f_wr);
      hi_oe    <= nx_cyc;
      ctl_oe   <= (state_d != S_HOLD);
      hlda     <= (state_d == S_HOLD);
      ad_out   <= nx_addr ? f_addr[DATA_W-1:0] : f_wdata;
      hi_out   <= nx_addr ? f_addr[ADDR_W-1:DATA_W] : f_stat;
      rd_valid <= capture && !lat_wr;
      if (capture && !lat_wr) rd_data <= ad_in;
    end
  end
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [HI_W-1:0]   req_stat,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   hi_out,
  output logic              hi_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              den_n,
  output logic              dtr_n,
  output logic              m_io,
  output logic              ctl_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  bus_state_e state_d;
  logic       take;
  logic       capture;

  mbus_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ready     (ready),
    .hold      (hold),
    .state_d   (state_d),
    .take      (take),
    .capture   (capture)
  );

  mbus_drive #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_drive (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .take      (take),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_mem   (req_mem),
    .req_wdata (req_wdata),
    .req_stat  (req_stat),
    .ad_in     (ad_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .hi_out    (hi_out),
    .hi_oe     (hi_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .den_n     (den_n),
    .dtr_n     (dtr_n),
    .m_io      (m_io),
    .ctl_oe    (ctl_oe),
    .hlda      (hlda),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign req_accept = take;
endmodule

// File: rtl/mbus_cycle_ctrl_chk.sv
module mbus_cycle_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ready,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic den_n,
  input logic dtr_n,
  input logic m_io,
  input logic ad_oe,
  input logic hi_oe,
  input logic ctl_oe,
  input logic hlda,
  input logic rd_valid
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n)); // R4
  AST_READ_DIR: assert property (@(posedge clk) disable iff (rst) !rd_n |-> (!dtr_n && !ad_oe && !den_n)); // R4
  AST_WRITE_DIR: assert property (@(posedge clk) disable iff (rst) !wr_n |-> (dtr_n && ad_oe && !den_n)); // R5
  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst) ale |=> !ale); // R2
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst) ale |-> (rd_n && wr_n && den_n && ad_oe && hi_oe)); // R2
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (rst) (!den_n && !ready) |=> !den_n); // R6
  AST_MIO_STABLE: assert property (@(posedge clk) disable iff (rst) (hi_oe && !ale) |-> $stable(m_io)); // R7
  AST_RDVALID_T4: assert property (@(posedge clk) disable iff (rst) rd_valid |-> (rd_n && wr_n && den_n && hi_oe && !dtr_n)); // R8
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (rst) hlda |-> (!ctl_oe && !ad_oe && !hi_oe)); // R9
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst) $rose(hlda) |-> $past(!hi_oe && rd_n && wr_n)); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (rst) $fell(hlda) |-> ctl_oe); // R10
endmodule

bind mbus_cycle_ctrl mbus_cycle_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ready    (ready),
  .ale      (ale),
  .rd_n     (rd_n),
  .wr_n     (wr_n),
  .den_n    (den_n),
  .dtr_n    (dtr_n),
  .m_io     (m_io),
  .ad_oe    (ad_oe),
  .hi_oe    (hi_oe),
  .ctl_oe   (ctl_oe),
  .hlda     (hlda),
  .rd_valid (rd_valid)
);

// File: tb/mbus_cycle_ctrl_bench.sv
module mbus_cycle_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int HI_W = ADDR_W - DATA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_accept;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic req_mem = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [HI_W-1:0] req_stat = '0;
  logic ready = 1'b1;
  logic hold = 1'b0;
  logic hlda;
  logic [DATA_W-1:0] ad_in = '0;
  logic [DATA_W-1:0] ad_out;
  logic ad_oe;
  logic [HI_W-1:0] hi_out;
  logic hi_oe, ale, rd_n, wr_n, den_n, dtr_n, m_io, ctl_oe;
  logic [DATA_W-1:0] rd_data;
  logic rd_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mbus_cycle_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_accept(req_accept),
    .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
    .req_wdata(req_wdata), .req_stat(req_stat), .ready(ready), .hold(hold),
    .hlda(hlda), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .hi_out(hi_out), .hi_oe(hi_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .den_n(den_n), .dtr_n(dtr_n), .m_io(m_io), .ctl_oe(ctl_oe),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              wr;
    logic              mem;
    logic [DATA_W-1:0] wdata;
    logic [HI_W-1:0]   stat;
    int                waits;
    logic [DATA_W-1:0] rdata;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor: follows transfers on the pins and compares against the queue
  exp_t cur;
  bit in_cyc = 0;
  int strobe_cnt = 0;
  always @(negedge clk) begin
    if (rst) begin
      in_cyc = 0;
    end else if (ale) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected transfer", 32'(ad_out), 0);
      end else begin
        cur = exp_q.pop_front();
        chk({hi_out, ad_out} == cur.addr && ad_oe && hi_oe, "R2 address phase",
            32'({hi_out, ad_out}), 32'(cur.addr));
        chk(m_io == cur.mem, "R7 m_io in T1", 32'(m_io), 32'(cur.mem));
        chk(dtr_n == cur.wr, "R4/R5 direction in T1", 32'(dtr_n), 32'(cur.wr));
        in_cyc = 1;
        strobe_cnt = 0;
      end
    end else if (in_cyc) begin
      if (!den_n) begin
        strobe_cnt++;
        if (cur.wr)
          chk(!wr_n && rd_n && dtr_n && ad_oe && ad_out == cur.wdata, "R5 write data phase",
              32'({wr_n, rd_n, dtr_n, ad_oe, ad_out}), 32'({4'b0111, cur.wdata}));
        else
          chk(!rd_n && wr_n && !dtr_n && !ad_oe, "R4 read data phase",
              32'({rd_n, wr_n, dtr_n, ad_oe}), 32'b0100);
        chk(hi_out == cur.stat && hi_oe, "R3 status on upper lines", 32'(hi_out), 32'(cur.stat));
        chk(m_io == cur.mem, "R7 m_io held", 32'(m_io), 32'(cur.mem));
      end else begin
        chk(strobe_cnt == 2 + cur.waits && rd_n && wr_n, "R6 strobe length",
            32'(strobe_cnt), 32'(2 + cur.waits));
        if (cur.wr)
          chk(!rd_valid && ad_oe && ad_out == cur.wdata, "R8/R5 write T4",
              32'({rd_valid, ad_out}), 32'(cur.wdata));
        else
          chk(rd_valid && rd_data == cur.rdata, "R8 read data in T4",
              32'({rd_valid, rd_data}), 32'({1'b1, cur.rdata}));
        in_cyc = 0;
      end
    end
  end

  // driver: queues the expectation, then drives one transfer
  task automatic run_cycle(input logic [ADDR_W-1:0] a, input logic wr, input logic mem,
                           input logic [DATA_W-1:0] wd, input logic [HI_W-1:0] st,
                           input int waits, input logic [DATA_W-1:0] rdat,
                           input bit noise, input bit hold_mid);
    exp_t e;
    e.addr = a; e.wr = wr; e.mem = mem; e.wdata = wd; e.stat = st;
    e.waits = waits; e.rdata = rdat;
    exp_q.push_back(e);
    @(negedge clk);
    req_addr = a; req_write = wr; req_mem = mem; req_wdata = wd; req_stat = st;
    req_valid = 1'b1;
    ready = 1'b1;
    #1;
    while (!req_accept) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);                 // T1
    req_valid = 1'b0;
    if (noise) ready = 1'b0;
    @(negedge clk);                 // T2: ready here must be ignored (R6)
    if (hold_mid) hold = 1'b1;
    if (noise) ready = 1'b0;
    ad_in = ~rdat;
    @(negedge clk);                 // T3
    ready = (waits == 0);
    ad_in = (waits == 0) ? rdat : ~rdat;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);               // TW
      ready = (i + 1 == waits);
      ad_in = (i + 1 == waits) ? rdat : ~rdat;
    end
    @(negedge clk);                 // T4
    ready = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    chk(rd_n && wr_n && den_n && ctl_oe && !ale && !ad_oe && !hi_oe && !hlda && !rd_valid,
        "R1 reset outputs", 32'({rd_n, wr_n, den_n, ctl_oe, ale, ad_oe, hi_oe, hlda, rd_valid}),
        32'b111100000);
    rst = 1'b0;

    // main function under several patterns
    run_cycle(20'h12345, 1'b0, 1'b1, 16'h0000, 4'h3, 0, 16'hBEEF, 1'b0, 1'b0); // R2 R4 R8 memory read
    run_cycle(20'hA5A5A, 1'b1, 1'b0, 16'hC0DE, 4'h5, 2, 16'h0000, 1'b1, 1'b0); // R5 R6 I/O write
    run_cycle(20'h0FFFF, 1'b0, 1'b0, 16'h0000, 4'hA, 3, 16'h1234, 1'b1, 1'b0); // R6 R8 I/O read, waits
    run_cycle(20'hFFFFF, 1'b1, 1'b1, 16'hFFFF, 4'hF, 1, 16'h0000, 1'b0, 1'b0); // R7 back to back
    run_cycle(20'h00001, 1'b0, 1'b1, 16'h0000, 4'h0, 0, 16'h8001, 1'b0, 1'b0);

    // R9: hold raised mid-transfer is deferred
    run_cycle(20'h54321, 1'b1, 1'b1, 16'h5A5A, 4'h6, 1, 16'h0000, 1'b0, 1'b1);
    chk(!hlda && ctl_oe, "R9 no grant in T4", 32'({hlda, ctl_oe}), 32'b01);
    @(negedge clk);
    chk(!hlda && ctl_oe, "R9 no grant in idle clock", 32'({hlda, ctl_oe}), 32'b01);
    @(negedge clk);
    chk(hlda && !ctl_oe && !ad_oe && !hi_oe, "R9 granted after transfer",
        32'({hlda, ctl_oe, ad_oe, hi_oe}), 32'b1000);
    hold = 1'b0;
    @(negedge clk);
    chk(!hlda && ctl_oe, "R10 release", 32'({hlda, ctl_oe}), 32'b01);

    // R9: hold wins over a pending request; R10: request taken after release
    begin
      exp_t e;
      e.addr = 20'h3C3C3; e.wr = 1'b1; e.mem = 1'b0; e.wdata = 16'h7E7E; e.stat = 4'h9;
      e.waits = 0; e.rdata = '0;
      exp_q.push_back(e);
      req_addr = e.addr; req_write = 1'b1; req_mem = 1'b0; req_wdata = e.wdata; req_stat = e.stat;
      hold = 1'b1;
      req_valid = 1'b1;
      #1;
      chk(!req_accept, "R9 hold beats request", 32'(req_accept), 0);
      @(negedge clk);
      #1;
      chk(hlda && !ctl_oe && !req_accept, "R9 hold entered", 32'({hlda, ctl_oe, req_accept}), 32'b100);
      @(negedge clk);
      #1;
      chk(hlda && !req_accept, "R9 stays in hold", 32'({hlda, req_accept}), 32'b10);
      hold = 1'b0;
      @(negedge clk);
      #1;
      chk(!hlda && ctl_oe && req_accept, "R10 request taken after release",
          32'({hlda, ctl_oe, req_accept}), 32'b011);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
    end

    // R1: reset aborts a transfer stuck in wait states
    begin
      exp_t e;
      e.addr = 20'h77777; e.wr = 1'b0; e.mem = 1'b1; e.wdata = '0; e.stat = 4'h1;
      e.waits = 9; e.rdata = '0;
      exp_q.push_back(e);
      req_addr = e.addr; req_write = 1'b0; req_mem = 1'b1; req_stat = e.stat;
      req_valid = 1'b1;
      ready = 1'b0;
      #1;
      while (!req_accept) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
      req_valid = 1'b0;
      repeat (4) @(negedge clk);
      chk(!rd_n && !den_n, "R6 held in wait state", 32'({rd_n, den_n}), 0);
      rst = 1'b1;
      @(negedge clk);
      chk(rd_n && wr_n && den_n && ctl_oe && !ale && !ad_oe && !hi_oe && !hlda && !rd_valid,
          "R1 abort by reset", 32'({rd_n, wr_n, den_n, ctl_oe, ale, ad_oe, hi_oe, hlda, rd_valid}),
          32'b111100000);
      repeat (3) @(negedge clk);
      ready = 1'b1;
      rst = 1'b0;
    end

    run_cycle(20'h2468A, 1'b0, 1'b0, 16'h0000, 4'h2, 0, 16'h4321, 1'b1, 1'b0); // after reset
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && !in_cyc, "R2 every request ran", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule